// File: doc/BRIEF.md
# Seven-Channel DMA Request Arbiter

This block decides which of seven DMA channels may move its next data item. Every channel can be started in one of two ways: by a dedicated hardware request line or by a software trigger. A per-channel mode bit selects which of the two counts. An enable bit gates the channel. A two-bit level, set by software, ranks the channel against the others. The arbiter registers each channel's request into a pending bit. It then picks one pending channel and drives a one-hot grant to it.

The grant stays fixed while the chosen channel transfers one item. The transfer engine reports the end of that item with a single-cycle `xfer_done` pulse. After that pulse the grant drops to zero for one cycle, and then a fresh round picks the next winner from the pending bits. The winner is the pending channel with the highest level. If several pending channels share that level, the one with the smallest index wins.

A software-started channel stays pending across items until it is disabled or its transfer count reaches zero. A hardware-started channel is pending exactly while its request line is high. The reset input is asynchronous and active-low. It is released inside the block through a two-stage synchronizer.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, `grant` is all zeros and `idle` is high.
- R2: A channel that is enabled and in hardware mode (`ch_sw_mode` bit 0) becomes pending on the clock edge that samples its `hw_req` high, and stops being pending on the edge that samples it low. When no grant is held, a grant to that channel appears one clock after it becomes pending.
- R3: A channel that is enabled and in software mode (`ch_sw_mode` bit 1) becomes pending on an edge that samples `sw_trig` high. It stays pending across any number of served items. It is cleared by an edge that samples `ch_cnt_zero` high, and the clear wins over a trigger in the same cycle. In software mode `hw_req` has no effect, and in hardware mode `sw_trig` has no effect.
- R4: A channel whose `ch_en` bit is low is never pending, whatever its request inputs are. Disabling a pending channel removes it from the next arbitration round.
- R5: The level of channel i is `ch_prio[2i+1:2i]`, where 3 is very high, 2 is high, 1 is medium and 0 is low. A round grants a channel of the highest level that any pending channel has.
- R6: Among pending channels that share the highest level, the channel with the smallest index is granted.
- R7: `grant` never has more than one bit set.
- R8: A nonzero grant holds its value until an `xfer_done` pulse. Changes in requests, enables or levels while the grant is held do not alter it. An `xfer_done` pulse while no grant is held has no effect.
- R9: The edge that samples `xfer_done` high with a grant held clears the grant. The next edge then grants the winner of the pending channels, or nothing if none is pending.
- R10: `idle` is high exactly in the cycles where `grant` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ch_en | input | 7 | Per-channel enable |
| ch_sw_mode | input | 7 | Per-channel source select: 1 uses the software trigger, 0 uses the hardware request line |
| hw_req | input | 7 | Hardware request lines, level sensitive |
| sw_trig | input | 7 | Software trigger pulses |
| ch_cnt_zero | input | 7 | Per-channel pulse: the channel's remaining item count has reached zero |
| ch_prio | input | 14 | Two-bit level per channel, channel i in bits [2i+1:2i] |
| xfer_done | input | 1 | Single-cycle pulse marking the end of the granted channel's item |
| grant | output | 7 | One-hot grant, all zeros when no channel is served |
| idle | output | 1 | High when no channel is granted |

## Verification
The hardest case to reach from the ports is a change in the pending set while a grant is held: a higher-level request arriving, the served channel being disabled, or a count-zero clear. Each of these must leave the grant untouched and must only show up in the round after the next `xfer_done`. Directed sequences set up these situations on purpose. They park a grant, alter the competitors, and then release the grant. A long random phase follows. It drives sparse triggers, clears and done pulses against a behavioural model that is compared on every cycle. This also covers `xfer_done` pulses that arrive when nothing is granted.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  localparam int unsigned PRIO_W     = 2;
  localparam int unsigned NUM_LEVELS = 1 << PRIO_W;

  typedef enum logic [PRIO_W-1:0] {
    LVL_LOW   = 2'd0,
    LVL_MED   = 2'd1,
    LVL_HIGH  = 2'd2,
    LVL_VHIGH = 2'd3
  } ch_level_e;

endpackage

// File: rtl/dma_arb_rst_sync.sv
module dma_arb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/dma_req_latch.sv
module dma_req_latch #(
  parameter int unsigned NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_sw_mode,
  input  logic [NUM_CH-1:0] hw_req,
  input  logic [NUM_CH-1:0] sw_trig,
  input  logic [NUM_CH-1:0] ch_cnt_zero,
  output logic [NUM_CH-1:0] pend
);

  logic [NUM_CH-1:0] pend_d;
  logic [NUM_CH-1:0] pend_q;

  // next-state: one slice per channel
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_comb begin
      if (!ch_en[c]) begin
        pend_d[c] = 1'b0;
      end else if (ch_sw_mode[c]) begin
        pend_d[c] = !ch_cnt_zero[c] && (pend_q[c] || sw_trig[c]);
      end else begin
        pend_d[c] = hw_req[c];
      end
    end

    AST_DISABLED_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[c] |=> !pend_q[c]); // R4
    AST_SW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[c] && ch_en[c] && ch_sw_mode[c] && !ch_cnt_zero[c]) |=> pend_q[c]); // R3
    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_sw_mode[c] && ch_cnt_zero[c]) |=> !pend_q[c]); // R3
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/dma_prio_select.sv
module dma_prio_select
  import dma_arb_pkg::*;
#(
  parameter int unsigned NUM_CH = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        pend,
  input  logic [NUM_CH*PRIO_W-1:0] ch_prio,
  output logic [NUM_CH-1:0]        winner,
  output logic                     any_pend
);

  logic [NUM_CH-1:0] lvl_pick [NUM_LEVELS];

  // one masked request vector per level, lowest index isolated
  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
    logic [NUM_CH-1:0] hit;
    always_comb begin
      for (int c = 0; c < NUM_CH; c++) begin
        hit[c] = pend[c] && (ch_prio[c*PRIO_W +: PRIO_W] == PRIO_W'(l));
      end
    end
    assign lvl_pick[l] = hit & (~hit + NUM_CH'(1));
  end

  // higher levels override lower ones
  always_comb begin
    winner = '0;
    for (int l = 0; l < NUM_LEVELS; l++) begin
      if (|lvl_pick[l]) begin
        winner = lvl_pick[l];
      end
    end
  end

  assign any_pend = |pend;

  function automatic int top_level(input logic [NUM_CH-1:0] p,
                                   input logic [NUM_CH*PRIO_W-1:0] pr);
    int best;
    best = -1;
    for (int c = 0; c < NUM_CH; c++) begin
      if (p[c] && int'(pr[c*PRIO_W +: PRIO_W]) > best) best = int'(pr[c*PRIO_W +: PRIO_W]);
    end
    return best;
  endfunction

  function automatic int first_at(input logic [NUM_CH-1:0] p,
                                  input logic [NUM_CH*PRIO_W-1:0] pr, input int lvl);
    for (int c = 0; c < NUM_CH; c++) begin
      if (p[c] && int'(pr[c*PRIO_W +: PRIO_W]) == lvl) return c;
    end
    return -1;
  endfunction

  AST_WINNER_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(winner) && ((winner != '0) == any_pend)); // R7
  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (winner & ~pend) == '0); // R5
  AST_WINNER_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |-> winner[first_at(pend, ch_prio, top_level(pend, ch_prio))]); // R6

endmodule

// File: rtl/dma_grant_ctrl.sv
module dma_grant_ctrl #(
  parameter int unsigned NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] winner,
  input  logic              any_pend,
  input  logic              xfer_done,
  output logic [NUM_CH-1:0] grant,
  output logic              idle
);

  logic [NUM_CH-1:0] grant_q;
  logic [NUM_CH-1:0] grant_d;
  logic              grant_en;
  logic              holding;

  assign holding = |grant_q;

  // next-state with explicit enable
  always_comb begin
    grant_en = 1'b0;
    grant_d  = grant_q;
    if (!holding) begin
      grant_en = 1'b1;
      grant_d  = winner;
    end else if (xfer_done) begin
      grant_en = 1'b1;
      grant_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
    end else if (grant_en) begin
      grant_q <= grant_d;
    end
  end

  assign grant = grant_q;
  assign idle  = !holding;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q)); // R7
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q != '0 && !xfer_done) |=> $stable(grant_q)); // R8
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q != '0 && xfer_done) |=> grant_q == '0); // R9
  AST_ROUND_TAKES_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q == '0 && any_pend) |=> grant_q != '0); // R9

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int unsigned NUM_CH = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        ch_en,
  input  logic [NUM_CH-1:0]        ch_sw_mode,
  input  logic [NUM_CH-1:0]        hw_req,
  input  logic [NUM_CH-1:0]        sw_trig,
  input  logic [NUM_CH-1:0]        ch_cnt_zero,
  input  logic [NUM_CH*PRIO_W-1:0] ch_prio,
  input  logic                     xfer_done,
  output logic [NUM_CH-1:0]        grant,
  output logic                     idle
);

  logic              rst_n_int;
  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] winner;
  logic              any_pend;

  dma_arb_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  dma_req_latch #(.NUM_CH(NUM_CH)) i_req_latch (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .ch_en       (ch_en),
    .ch_sw_mode  (ch_sw_mode),
    .hw_req      (hw_req),
    .sw_trig     (sw_trig),
    .ch_cnt_zero (ch_cnt_zero),
    .pend        (pend)
  );

  dma_prio_select #(.NUM_CH(NUM_CH)) i_prio_select (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .pend     (pend),
    .ch_prio  (ch_prio),
    .winner   (winner),
    .any_pend (any_pend)
  );

  dma_grant_ctrl #(.NUM_CH(NUM_CH)) i_grant_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .winner    (winner),
    .any_pend  (any_pend),
    .xfer_done (xfer_done),
    .grant     (grant),
    .idle      (idle)
  );

  AST_GRANT_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_n_int)
    (grant == '0) |=> ((grant & ~$past(pend)) == '0)); // R4

endmodule

// File: tb/test_dma_req_arbiter.sv
module test_dma_req_arbiter;

  localparam int NCH = 7;

  logic           clk;
  logic           rst_n;
  logic [NCH-1:0] ch_en, ch_sw_mode, hw_req, sw_trig, ch_cnt_zero;
  logic [2*NCH-1:0] ch_prio;
  logic           xfer_done;
  logic [NCH-1:0] grant;
  logic           idle;

  int checks;
  int failures;

  dma_req_arbiter #(.NUM_CH(NCH)) i_dma_req_arbiter (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_sw_mode(ch_sw_mode),
    .hw_req(hw_req), .sw_trig(sw_trig), .ch_cnt_zero(ch_cnt_zero),
    .ch_prio(ch_prio), .xfer_done(xfer_done), .grant(grant), .idle(idle)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_pend [NCH];
  int m_gnt;

  function automatic int lvl(input int c);
    return int'(ch_prio[2*c +: 2]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_pend[i]) m_pend[i] = 1'b0;
      m_gnt = -1;
    end else begin
      int best;
      best = -1;
      for (int c = 0; c < NCH; c++) begin
        if (m_pend[c] && (best < 0 || lvl(c) > lvl(best))) best = c;
      end
      if (m_gnt < 0) m_gnt = best;
      else if (xfer_done) m_gnt = -1;
      for (int c = 0; c < NCH; c++) begin
        if (!ch_en[c]) m_pend[c] = 1'b0;
        else if (ch_sw_mode[c]) m_pend[c] = !ch_cnt_zero[c] && (m_pend[c] || sw_trig[c]);
        else m_pend[c] = hw_req[c];
      end
    end
  end

  bit mon_on;
  always @(negedge clk) begin
    if (mon_on) begin
      int expv;
      expv = (m_gnt < 0) ? 0 : (1 << m_gnt);
      chk($countones(grant) <= 1, "R7 grant onehot", int'(grant), expv);
      chk(int'(grant) == expv, "R9 grant vs model", int'(grant), expv);
      chk(idle == (grant == '0), "R10 idle flag", int'(idle), int'(grant == '0));
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic set_lvl(input int c, input int l);
    ch_prio[2*c +: 2] = 2'(l);
  endtask

  task automatic done_pulse();
    xfer_done = 1'b1;
    cyc(1);
    xfer_done = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0; mon_on = 1'b0;
    rst_n = 1'b0; ch_en = '0; ch_sw_mode = '0; hw_req = '0; sw_trig = '0;
    ch_cnt_zero = '0; ch_prio = '0; xfer_done = 1'b0;
    cyc(5);
    rst_n = 1'b1;
    cyc(4);
    chk(grant == '0, "R1 reset grant", int'(grant), 0);
    chk(idle == 1'b1, "R1 reset idle", int'(idle), 1);
    mon_on = 1'b1;

    // R2: hardware request latency
    ch_en[2] = 1; hw_req[2] = 1; set_lvl(2, 1);
    cyc(1);
    chk(grant == '0, "R2 one cycle latch", int'(grant), 0);
    cyc(1);
    chk(grant == 7'b0000100, "R2 hw grant", int'(grant), 'h04);
    chk(idle == 1'b0, "R10 idle low while granted", int'(idle), 0);

    // R8: hold against a new competitor
    ch_en[0] = 1; hw_req[0] = 1; set_lvl(0, 3);
    cyc(3);
    chk(grant == 7'b0000100, "R8 grant held", int'(grant), 'h04);
    set_lvl(0, 1);
    done_pulse();
    chk(grant == '0, "R9 release gap", int'(grant), 0);
    chk(idle == 1'b1, "R10 idle in gap", int'(idle), 1);
    cyc(1);
    chk(grant == 7'b0000001, "R6 tie lowest index", int'(grant), 'h01);
    hw_req[0] = 0; hw_req[2] = 0;
    done_pulse();
    cyc(1);
    chk(grant == '0, "R2 dropped request", int'(grant), 0);
    ch_en = '0;

    // R5: level ordering
    ch_en[1] = 1; ch_en[3] = 1; ch_en[5] = 1;
    set_lvl(1, 0); set_lvl(3, 2); set_lvl(5, 3);
    hw_req[1] = 1; hw_req[3] = 1; hw_req[5] = 1;
    cyc(2);
    chk(grant == 7'b0100000, "R5 very high first", int'(grant), 'h20);
    hw_req[5] = 0;
    done_pulse();
    cyc(1);
    chk(grant == 7'b0001000, "R5 high next", int'(grant), 'h08);
    hw_req = '0;
    done_pulse();
    cyc(2);
    ch_en = '0;

    // R4: disabled channel
    hw_req[4] = 1; set_lvl(4, 3);
    cyc(3);
    chk(grant == '0, "R4 disabled ignored", int'(grant), 0);
    ch_en[4] = 1;
    cyc(2);
    chk(grant == 7'b0010000, "R4 enabled grant", int'(grant), 'h10);
    ch_en[4] = 0;
    cyc(2);
    chk(grant == 7'b0010000, "R8 hold across disable", int'(grant), 'h10);
    done_pulse();
    cyc(1);
    chk(grant == '0, "R4 disabled not regranted", int'(grant), 0);
    hw_req[4] = 0;

    // R3: software trigger
    ch_en[6] = 1; ch_sw_mode[6] = 1; set_lvl(6, 0); hw_req[6] = 1;
    cyc(3);
    chk(grant == '0, "R3 hw ignored in sw mode", int'(grant), 0);
    sw_trig[6] = 1; cyc(1); sw_trig[6] = 0;
    cyc(1);
    chk(grant == 7'b1000000, "R3 sw grant", int'(grant), 'h40);
    done_pulse();
    cyc(1);
    chk(grant == 7'b1000000, "R3 sw stays pending", int'(grant), 'h40);
    ch_cnt_zero[6] = 1; sw_trig[6] = 1; cyc(1); ch_cnt_zero[6] = 0; sw_trig[6] = 0;
    done_pulse();
    cyc(2);
    chk(grant == '0, "R3 count zero clears", int'(grant), 0);
    hw_req[6] = 0;
    ch_en[4] = 1; sw_trig[4] = 1; cyc(1); sw_trig[4] = 0;
    cyc(2);
    chk(grant == '0, "R3 trigger ignored in hw mode", int'(grant), 0);
    ch_en[4] = 0;
    xfer_done = 1; cyc(2); xfer_done = 0;
    chk(grant == '0, "R8 done without grant", int'(grant), 0);

    // random phase against the model
    for (int k = 0; k < 4000; k++) begin
      if (k % 50 == 0) begin
        ch_en = 7'($urandom); ch_sw_mode = 7'($urandom); ch_prio = 14'($urandom);
      end
      hw_req = 7'($urandom);
      for (int c = 0; c < NCH; c++) begin
        sw_trig[c] = ($urandom % 8) == 0;
        ch_cnt_zero[c] = ($urandom % 16) == 0;
      end
      xfer_done = ($urandom % 3) == 0;
      cyc(1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule